// File: doc/BRIEF.md
# Multiplexed Address/Data Register Port

This block is the slave end of an 8-bit shared address/data bus driven by a small host controller. The host first places an address on the bus and lowers the address strobe. It then places a data byte and lowers the data strobe. Both strobes idle high. They are brought into the block's clock domain, and their falling edges are detected there, so each captured address and each register write takes exactly one clock cycle.

The register file holds pulse start/stop bytes, one shared register that collects the ninth bits of several 9-bit values, and mode bytes. The block presents each 9-bit value already assembled, alongside the raw bytes.

Reading needs no separate read strobe. The host sends a special arming address. The next address cycle then becomes a read. While the data strobe is low during that read, the block drives the bus with either the low byte of a measured field length, or the top two bits of that length together with status bits. When the data strobe rises, the port returns on its own to write mode and releases the bus.

Top module: `mux_reg_port`

## Requirements
- R1: After reset every register byte is zero, the bus is released (bus_oe low) and the port is in write mode.
- R2: The address byte is taken from bus_in at the synchronised falling edge of ale. bus_in must be held stable until that edge has been detected.
- R3: In write mode, a synchronised falling edge of wrd stores bus_in into register index (address − 0x40), for addresses 0x40 to 0x4F. A later write to the same address overwrites the earlier value.
- R4: A data strobe whose latched address lies outside 0x40–0x4F changes no register.
- R5: Assembled value k (k = 0..7) is {bit k of register 0x48, register byte 0x40+k}, nine bits wide, and is output on val9_o[9k+8:9k].
- R6: Latching address 0x80 in write mode arms read mode. While armed, a data strobe writes nothing and the bus stays released.
- R7: The address latched after arming selects the read. While wrd is low (synchronised), bus_oe is high. If that address is 0x81, bus_out carries fld_len[7:0].
- R8: In the read cycle, address 0x80 returns {fld_stat[5:0], fld_len[9], fld_len[8]}, and any other address returns 0x00.
- R9: When wrd rises after the read, bus_oe falls and the port returns to write mode, so the next address/data cycle is an ordinary write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address strobe, active low, asynchronous |
| wrd | input | 1 | Data strobe (write; read enable during a read cycle), active low |
| bus_in | input | 8 | Bus value seen at the pins |
| bus_out | output | 8 | Value driven onto the bus when bus_oe is high, else zero |
| bus_oe | output | 1 | Output enable for the bus drivers |
| fld_len | input | 10 | Measured field length |
| fld_stat | input | 6 | Status bits (such as the current field identity) |
| regs_o | output | 128 | Register bytes, index i at bits [8i+7:8i] |
| val9_o | output | 72 | Assembled 9-bit start/stop values |

## Verification
The assertions assume the host keeps the protocol. Strobes stay high for at least three clocks between falls. bus_in holds steady until a fall has passed through the two synchroniser stages. The data strobe is never low while the address strobe falls. The stimulus tasks change bus_in only together with a strobe edge and hold every strobe level for four clock periods. The strobes therefore never overlap, and every edge is seen exactly once.

// File: rtl/mux_reg_port.sv
module mux_reg_port #(
  parameter int         NREG   = 16,
  parameter int         NVAL   = 8,
  parameter logic [7:0] BASE   = 8'h40,
  parameter logic [7:0] RD_KEY = 8'h80,
  parameter logic [7:0] RD_LO  = 8'h81
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ale,
  input  logic                 wrd,
  input  logic [7:0]           bus_in,
  output logic [7:0]           bus_out,
  output logic                 bus_oe,
  input  logic [9:0]           fld_len,
  input  logic [5:0]           fld_stat,
  output logic [NREG*8-1:0]    regs_o,
  output logic [NVAL*9-1:0]    val9_o
);
  localparam int IW     = $clog2(NREG);
  localparam int MSBREG = NVAL;

  typedef enum logic [1:0] {S_WR, S_ARM, S_RD} mode_t;

  mode_t       mode;
  logic [2:0]  ale_p, wrd_p;
  logic [7:0]  addr_q;
  logic [7:0]  rf [NREG];

  wire ale_fall = ale_p[2] & ~ale_p[1];
  wire wrd_fall = wrd_p[2] & ~wrd_p[1];
  wire wrd_rise = ~wrd_p[2] & wrd_p[1];
  wire [8:0] offs = {1'b0, addr_q} - {1'b0, BASE};
  wire in_win  = (addr_q >= BASE) && (offs < 9'(NREG));
  wire wr_pulse = wrd_fall && (mode == S_WR) && in_win;
  wire [IW-1:0] widx = offs[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_p <= '1;
      wrd_p <= '1;
    end else begin
      ale_p <= {ale_p[1:0], ale};
      wrd_p <= {wrd_p[1:0], wrd};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= S_WR;
      addr_q <= '0;
    end else if (ale_fall) begin
      addr_q <= bus_in;
      case (mode)
        S_WR:    mode <= (bus_in == RD_KEY) ? S_ARM : S_WR;
        S_ARM:   mode <= S_RD;
        default: mode <= (bus_in == RD_KEY) ? S_ARM : S_WR;
      endcase
    end else if (wrd_rise && mode == S_RD) begin
      mode <= S_WR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (wr_pulse) begin
      rf[widx] <= bus_in;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_flat
      assign regs_o[g*8 +: 8] = rf[g];
    end
    for (g = 0; g < NVAL; g++) begin : g_val
      assign val9_o[g*9 +: 9] = {rf[MSBREG][g], rf[g]};
    end
  endgenerate

  logic [7:0] rd_data;
  always_comb begin
    if (addr_q == RD_LO)       rd_data = fld_len[7:0];
    else if (addr_q == RD_KEY) rd_data = {fld_stat, fld_len[9:8]};
    else                       rd_data = 8'h00;
  end

  assign bus_oe  = (mode == S_RD) && !wrd_p[1];
  assign bus_out = bus_oe ? rd_data : 8'h00;

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
  a_r4_no_write_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (wrd_fall && !in_win) |=> $stable(regs_o));
  a_r6_arm_on_key: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == S_WR && ale_fall && bus_in == RD_KEY) |=> mode == S_ARM);
  a_r6_armed_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != S_WR) |=> $stable(regs_o));
  a_r6_armed_released: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == S_ARM) |-> !bus_oe);
  a_r9_release_to_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe) |=> mode != S_RD);
endmodule

// File: tb/mux_reg_port_tb.sv
module mux_reg_port_tb;
  logic clk = 0, rst_n = 0, ale = 1, wrd = 1;
  logic [7:0] bus_in = 0, bus_out;
  logic bus_oe;
  logic [9:0] fld_len = 10'h2C7;
  logic [5:0] fld_stat = 6'h15;
  logic [127:0] regs_o;
  logic [71:0] val9_o;
  int errors = 0, checks = 0;
  logic [7:0] model [16];

  always #5 clk = ~clk;

  mux_reg_port u_dut (.clk, .rst_n, .ale, .wrd, .bus_in, .bus_out, .bus_oe,
    .fld_len, .fld_stat, .regs_o, .val9_o);

  localparam int NV = 7;
  localparam logic [15:0] VEC [NV] = '{16'h40A5, 16'h473C, 16'h4881, 16'h4FFF,
                                       16'h3F11, 16'h5022, 16'h405A};

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_addr(logic [7:0] a);
    @(negedge clk); bus_in = a; ale = 0; wait_n(4); ale = 1; wait_n(3);
  endtask

  task automatic send_data(logic [7:0] d);
    @(negedge clk); bus_in = d; wrd = 0; wait_n(4); wrd = 1; wait_n(3);
  endtask

  function automatic logic [127:0] flat_model();
    logic [127:0] f;
    for (int i = 0; i < 16; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic do_read(logic [7:0] a, logic [7:0] exp, string req);
    send_addr(8'h80);
    send_addr(a);
    @(negedge clk); bus_in = 8'h00; wrd = 0; wait_n(4);
    chk({req, " oe during read"}, 128'(bus_oe), 128'(1));
    chk({req, " read data"}, 128'(bus_out), 128'(exp));
    wrd = 1; wait_n(4);
    chk("R9 bus released", 128'(bus_oe), 128'(0));
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    wait_n(3); rst_n = 1; wait_n(2);
    chk("R1 regs zero", regs_o, 128'(0));
    chk("R1 bus released", 128'(bus_oe), 128'(0));

    for (int v = 0; v < NV; v++) begin
      logic [7:0] a, d;
      a = VEC[v][15:8]; d = VEC[v][7:0];
      send_addr(a); send_data(d);
      if (a >= 8'h40 && a <= 8'h4F) model[a - 8'h40] = d;
      chk((a >= 8'h40 && a <= 8'h4F) ? "R3 write" : "R4 outside ignored",
          regs_o, flat_model());
    end

    chk("R5 value0", 128'(val9_o[8:0]), 128'(9'h15A));
    chk("R5 value7", 128'(val9_o[71:63]), 128'(9'h13C));
    chk("R5 value1", 128'(val9_o[17:9]), 128'(9'h000));

    send_addr(8'h80);
    @(negedge clk); bus_in = 8'h77; wrd = 0; wait_n(4);
    chk("R6 armed no drive", 128'(bus_oe), 128'(0));
    wrd = 1; wait_n(3);
    chk("R6 armed no write", regs_o, flat_model());
    send_addr(8'h81);
    @(negedge clk); wrd = 0; wait_n(4);
    chk("R7 oe", 128'(bus_oe), 128'(1));
    chk("R7 low byte", 128'(bus_out), 128'(8'hC7));
    wrd = 1; wait_n(4);
    chk("R9 released", 128'(bus_oe), 128'(0));

    do_read(8'h81, 8'hC7, "R7");
    do_read(8'h80, 8'h56, "R8");
    do_read(8'h45, 8'h00, "R8 other");
    chk("R6 regs unchanged by reads", regs_o, flat_model());

    send_addr(8'h41); send_data(8'h99); model[1] = 8'h99;
    chk("R9 write after read", regs_o, flat_model());
    chk("R9 no drive on write", 128'(bus_oe), 128'(0));

    send_addr(8'h4A); send_data(8'h12); model[10] = 8'h12;
    send_data(8'h34); model[10] = 8'h34;
    chk("R2 address held for second write", regs_o, flat_model());

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule